// File: doc/BRIEF.md
# Transmit Jabber Watchdog

This block sits between the MAC's transmit-enable line and a 10 Mb/s Ethernet physical layer and cuts off runaway transmissions. It counts millisecond ticks while transmit enable stays high. Once a single unbroken transmission runs past the jabber limit, the block latches into a jabbing state.

While jabbing, the block holds the transmitter off whatever the MAC requests. It withdraws the automatic transmit-to-receive loopback used in twisted-pair mode, signals a collision to the MAC and lights a jabber LED. It leaves that state only after the transmit request has stayed low for an unbroken unjab interval. Any request during that wait starts the wait over.

Both intervals are parameters in whole ticks, so a bench can shorten them. The defaults are 32 and 256 ticks, which is 32 ms and 256 ms with a 1 ms tick.

Top module: `jabber_guard`

## Requirements
- R1: With `tx_en_i` held high, jabbing begins on the clock edge one cycle after the (JAB_MS+1)-th tick seen during that transmission. After only JAB_MS ticks the block is not jabbing.
- R2: `tx_gate_o` equals `tx_en_i` when not jabbing. It is 0 while jabbing.
- R3: `lpbk_en_o` is 1 only when `tp_mode_i` is 1 (twisted-pair mode) and the block is not jabbing. In coax mode (`tp_mode_i` = 0) it is 0.
- R4: `col_o` is 1 exactly while jabbing.
- R5: `led_jab_o` is 1 exactly while jabbing.
- R6: Jabbing ends one cycle after the UNJAB_MS-th tick counted while `tx_en_i` is low. After UNJAB_MS-1 such ticks it is still jabbing.
- R7: A high `tx_en_i` during the unjab wait clears the idle count. A further UNJAB_MS idle ticks are then needed before release.
- R8: When `tx_en_i` falls, the transmit-duration count clears. A new transmission starts again from zero.
- R9: While `rst_n` is low, all outputs are in the non-jabbing state and both counts are zero. Release from reset takes two clock edges.
- R10: Ticks that arrive while not jabbing and with `tx_en_i` low have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en_i | input | 1 | Transmit enable from the MAC |
| tp_mode_i | input | 1 | 1 = twisted-pair mode, 0 = coax attachment mode |
| ms_tick_i | input | 1 | One-cycle pulse per millisecond |
| tx_gate_o | output | 1 | Transmit enable passed to the line driver |
| lpbk_en_o | output | 1 | Enable for the transmit-to-receive loopback |
| col_o | output | 1 | Collision indication to the MAC |
| led_jab_o | output | 1 | Jabber LED drive |

## Verification
The bench steps through the exact tick count on each side of both thresholds. An off-by-one in either counter would therefore show up as jabbing one tick early or late, or releasing one tick early or late.

It reasserts transmit enable midway through the unjab wait. A design that only paused the idle count would release too soon.

It drops transmit enable just short of the limit and then starts again. A design that kept the old duration would jab on the second, short transmission.

It also sends ticks while idle and checks loopback in both modes. This catches a design that counts idle time outside the jabbing state, or that enables loopback in coax mode.

// File: rtl/jabber_guard_pkg.sv
package jabber_guard_pkg;
  typedef enum logic [0:0] {
    ST_RUN = 1'b0,
    ST_JAB = 1'b1
  } jab_state_t;
endpackage

// File: rtl/jabber_rst_sync.sv
module jabber_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/jabber_tick_cnt.sv
module jabber_tick_cnt #(
  parameter int LIMIT = 33
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  input  logic clr,
  output logic at_lim
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr | (tick & run & (cnt_q != LIM));
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign at_lim = (cnt_q == LIM);

  // Count never passes its limit (R1, R6)
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM);

  // A counted tick advances by exactly one (R6)
  p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && !clr && cnt_q != LIM) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/jabber_guard.sv
module jabber_guard
  import jabber_guard_pkg::*;
#(
  parameter int JAB_MS   = 32,
  parameter int UNJAB_MS = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en_i,
  input  logic tp_mode_i,
  input  logic ms_tick_i,
  output logic tx_gate_o,
  output logic lpbk_en_o,
  output logic col_o,
  output logic led_jab_o
);
  localparam int DUR_LIMIT = JAB_MS + 1;

  logic       rst_n_int;
  jab_state_t st_q, st_d;
  logic       jab;
  logic       dur_run, dur_clr, dur_hit;
  logic       idl_run, idl_clr, idl_hit;

  jabber_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  assign jab = (st_q == ST_JAB);

  // Duration of the current transmission, only outside jabbing
  assign dur_run = tx_en_i & ~jab;
  assign dur_clr = ~tx_en_i | jab;

  jabber_tick_cnt #(.LIMIT(DUR_LIMIT)) u_dur (
    .clk(clk), .rst_n(rst_n_int), .tick(ms_tick_i),
    .run(dur_run), .clr(dur_clr), .at_lim(dur_hit)
  );

  // Continuous idle time while jabbing
  assign idl_run = ~tx_en_i & jab;
  assign idl_clr = tx_en_i | ~jab;

  jabber_tick_cnt #(.LIMIT(UNJAB_MS)) u_idle (
    .clk(clk), .rst_n(rst_n_int), .tick(ms_tick_i),
    .run(idl_run), .clr(idl_clr), .at_lim(idl_hit)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN: if (dur_hit)             st_d = ST_JAB;
      ST_JAB: if (idl_hit && !tx_en_i) st_d = ST_RUN;
      default:                         st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) st_q <= ST_RUN;
    else            st_q <= st_d;
  end

  assign tx_gate_o = tx_en_i & ~jab;
  assign lpbk_en_o = tp_mode_i & ~jab;
  assign col_o     = jab;
  assign led_jab_o = jab;

  // Entry into jabbing only follows an active transmit request
  p_entry_tx_r1: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(jab) |-> $past(tx_en_i));

  // Release only follows an idle request
  p_exit_idle_r6: assert property (@(posedge clk) disable iff (!rst_n_int)
    $fell(jab) |-> !$past(tx_en_i));

  // A request while jabbing keeps the latch for the next cycle
  p_req_holds_r7: assert property (@(posedge clk) disable iff (!rst_n_int)
    (jab && tx_en_i) |=> jab);

  // Line driver never sees an enable while jabbing
  p_gate_off_r2: assert property (@(posedge clk) disable iff (!rst_n_int)
    col_o |-> !tx_gate_o);
endmodule

// File: tb/jabber_guard_tb.sv
module jabber_guard_tb;
  localparam int JAB   = 4;
  localparam int UNJAB = 6;

  logic clk = 1'b0;
  logic rst_n, tx_en, tp_mode, tick;
  logic tx_gate, lpbk, col, led;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  jabber_guard #(.JAB_MS(JAB), .UNJAB_MS(UNJAB)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_en_i(tx_en), .tp_mode_i(tp_mode),
    .ms_tick_i(tick), .tx_gate_o(tx_gate), .lpbk_en_o(lpbk),
    .col_o(col), .led_jab_o(led)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b (gate,lpbk,col,led)", req, act, exp);
    end
  endtask

  // Expected output bundle from the requirements
  function automatic logic [3:0] model(input logic jabbing);
    return {tx_en & ~jabbing, tp_mode & ~jabbing, jabbing, jabbing};
  endfunction

  function automatic logic [3:0] outs();
    return {tx_gate, lpbk, col, led};
  endfunction

  task automatic pulse_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0; tx_en = 1'b0; tick = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 in reset", outs(), model(1'b0));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    tp_mode = 1'b1;
    do_reset();
    check("R9 after reset", outs(), model(1'b0));
  endtask

  task automatic t_jab_entry();
    do_reset();
    @(negedge clk) tx_en = 1'b1;
    pulse_ticks(JAB);
    check("R1 at limit no jab / R2 pass", outs(), model(1'b0));
    pulse_ticks(1);
    check("R1 jab entered, R2/R3/R4/R5", outs(), model(1'b1));
    tx_en = 1'b0; @(negedge clk);
    check("R2 still jabbing with tx low", outs(), model(1'b1));
  endtask

  task automatic t_unjab();
    pulse_ticks(UNJAB - 1);
    check("R6 one tick short", outs(), model(1'b1));
    pulse_ticks(1);
    check("R6 released", outs(), model(1'b0));
    tx_en = 1'b1; @(negedge clk);
    check("R2 gate follows after release", outs(), model(1'b0));
    tx_en = 1'b0; @(negedge clk);
  endtask

  task automatic t_restart_wait();
    do_reset();
    @(negedge clk) tx_en = 1'b1;
    pulse_ticks(JAB + 1);
    tx_en = 1'b0;
    pulse_ticks(UNJAB - 2);
    tx_en = 1'b1;
    pulse_ticks(1);
    check("R7 request while waiting", outs(), model(1'b1));
    tx_en = 1'b0;
    pulse_ticks(UNJAB - 1);
    check("R7 old idle count discarded", outs(), model(1'b1));
    pulse_ticks(1);
    check("R7 released after full wait", outs(), model(1'b0));
  endtask

  task automatic t_dur_restart();
    do_reset();
    @(negedge clk) tx_en = 1'b1;
    pulse_ticks(JAB);
    tx_en = 1'b0; @(negedge clk);
    tx_en = 1'b1;
    pulse_ticks(JAB);
    check("R8 fresh transmission no jab", outs(), model(1'b0));
    pulse_ticks(1);
    check("R8 fresh count reaches limit", outs(), model(1'b1));
    tx_en = 1'b0;
    pulse_ticks(UNJAB);
  endtask

  task automatic t_idle_ticks();
    do_reset();
    pulse_ticks(JAB + UNJAB + 3);
    check("R10 idle ticks ignored", outs(), model(1'b0));
    @(negedge clk) tx_en = 1'b1; @(negedge clk);
    check("R10 no carried count", outs(), model(1'b0));
    tx_en = 1'b0; @(negedge clk);
  endtask

  task automatic t_coax_mode();
    do_reset();
    tp_mode = 1'b0; @(negedge clk);
    check("R3 coax mode loopback off", outs(), model(1'b0));
    tx_en = 1'b1;
    pulse_ticks(JAB + 1);
    check("R3/R4 coax jabbing", outs(), model(1'b1));
    tp_mode = 1'b1; @(negedge clk);
    check("R3 tp jabbing loopback off", outs(), model(1'b1));
    @(negedge clk) rst_n = 1'b0; #1;
    check("R9 async reset clears jab", outs(), {tx_en, tp_mode, 2'b00});
    tx_en = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; tx_en = 1'b0; tp_mode = 1'b1; tick = 1'b0;
    t_reset();
    t_jab_entry();
    t_unjab();
    t_restart_wait();
    t_dur_restart();
    t_idle_ticks();
    t_coax_mode();
    done = 1'b1;
  end

  initial begin : watchdog
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule